// File: doc/BRIEF.md
# Floppy Drive Control Register Block

This block holds the host-visible control state of a PC-style floppy controller and turns it into the signals that face the drives: active-low drive selects and motor enables, a drive 2/3 indicator, two data-rate lines, a density-select line and a qualified DMA acknowledge. A byte-wide write bus loads five small registers: the output control register, the tape/exchange register, the rate select register, the configuration control register and a feature enable register.

Drive selects are decoded from the selected-drive field and gated by the per-drive motor bits. A four-drive mode puts an encoded drive address on the select pins for an external decoder. The data-rate lines follow whichever rate-bearing register was written last, and the density line derives from that rate with a polarity set by a drive-type strap. A step-direction line is passed through only while a seek is in progress.

Top module: `fdc_drive_ctl`

## Requirements
- R1: After a synchronous active-low reset, the output control register is 0 (no drive selected, all motors off), the rate code is 2'b10, `drv23_o` is 0, the DMA acknowledge is blocked, and the four-drive, PS/2 and exchange bits are 0.
- R2: Register addresses are 0 output control, 1 tape/exchange, 2 rate select, 3 configuration control, 4 feature enable. In two-drive mode, `sel_n_o[i]` (i = 0,1) is low only when output control bits 1:0 equal i and motor bit 4+i is set; at most one select is low.
- R3: In two-drive mode, `mot_n_o[i]` is the inverse of output control bit 4+i.
- R4: When feature enable bit 4 is set (four-drive mode), `sel_n_o` carries the inverse of output control bits 1:0, `mot_n_o[0]` is low when the motor bit of the selected drive (bit 4 + drive number) is set, and `mot_n_o[1]` is low when any motor bit 7:4 is set.
- R5: `drv23_o` is high when drive 2 or 3 is selected (output control bit 1 set) and that drive's motor bit is set, in either drive mode.
- R6: `drv23_o` stays low whenever exchange bit 3 of the tape/exchange register is set.
- R7: `rate_o` shows bits 1:0 of the most recent write to either the rate select or the configuration control register.
- R8: With the strap `dtype_i` high, `dens_o` is high for rate codes 2'b00 (500 kbps) and 2'b11 (1 Mbps) and low for 2'b01 (300 kbps) and 2'b10 (250 kbps).
- R9: With `dtype_i` low, `dens_o` is the inverse of the R8 value.
- R10: With feature enable bit 0 clear (AT mode), `dack_n_o` follows `dack_n_i` only while output control bit 3 is set, and is held high otherwise.
- R11: With feature enable bit 0 set (PS/2 mode), `dack_n_o` always follows `dack_n_i`, whatever output control bit 3 holds.
- R12: `dir_o` equals `seek_in_i` while `seek_busy_i` is high and is low otherwise.
- R13: A write updates its register on the rising edge where `wr_en_i` is high, and outputs reflect it right after that edge; cycles without `wr_en_i`, and writes to addresses 5 to 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| dtype_i | input | 1 | Drive-type strap, sets density polarity |
| dack_n_i | input | 1 | Raw DMA acknowledge, active low |
| seek_busy_i | input | 1 | High while a seek runs |
| seek_in_i | input | 1 | Requested step direction, high is inward |
| sel_n_o | output | 2 | Drive selects or encoded drive address, active low |
| mot_n_o | output | 2 | Motor enables, active low |
| drv23_o | output | 1 | Drive 2 or 3 accessed |
| rate_o | output | 2 | Current data-rate code |
| dens_o | output | 1 | Density select |
| dack_n_o | output | 1 | Qualified DMA acknowledge, active low |
| dir_o | output | 1 | Step direction toward the drive |

## Verification
The hardest state to reach is a drive 2 or 3 selection with its motor bit on while the exchange bit is set, in both drive modes, because it needs three registers lined up at once. The bench reaches it with a directed sequence and also by random writes that hit the tape/exchange, output control and feature registers often enough to cover every combination. The rate ordering is exercised by writing the two rate registers with different codes back to back in both orders.

// File: rtl/fdc_drive_pkg.sv
// Shared constants for the floppy drive control block.
// Assumes a 3-bit register address space; unused addresses are ignored.
package fdc_drive_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_OUTCTL = 3'd0;
    localparam logic [ADDR_W-1:0] A_TAPE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_RSEL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CFGC   = 3'd3;
    localparam logic [ADDR_W-1:0] A_FEAT   = 3'd4;

    typedef enum logic [1:0] {
        RATE_500K = 2'b00,
        RATE_300K = 2'b01,
        RATE_250K = 2'b10,
        RATE_1M   = 2'b11
    } rate_code_e;

    localparam logic [1:0] RATE_RESET = RATE_250K;
    localparam int XCHG_BIT  = 3;
    localparam int FOUR_BIT  = 4;
    localparam int PS2_BIT   = 0;
    localparam int DMAEN_BIT = 3;
endpackage

// File: rtl/fdc_ctl_regs.sv
// Register file of the drive control block.
// Holds the output control byte, the exchange bit, the feature bits and the
// current rate code. Both rate-bearing registers load the same rate field, so
// the field always reflects whichever was written last. Assumes writes are
// single-cycle strobes synchronous to clk.
module fdc_ctl_regs
    import fdc_drive_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    outctl_q,
    output logic          xchg_q,
    output logic          four_q,
    output logic          ps2_q,
    output logic [1:0]    rate_q
);

    // Load the addressed register on a strobed edge; reset to the idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outctl_q <= 8'h00;
            xchg_q   <= 1'b0;
            four_q   <= 1'b0;
            ps2_q    <= 1'b0;
            rate_q   <= RATE_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                A_OUTCTL: outctl_q <= wr_data;
                A_TAPE:   xchg_q   <= wr_data[XCHG_BIT];
                A_RSEL:   rate_q   <= wr_data[1:0];
                A_CFGC:   rate_q   <= wr_data[1:0];
                A_FEAT: begin
                    four_q <= wr_data[FOUR_BIT];
                    ps2_q  <= wr_data[PS2_BIT];
                end
                default: ;
            endcase
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (outctl_q == 8'h00 && rate_q == RATE_RESET && !xchg_q && !four_q && !ps2_q));

    assert_rate_last_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_RSEL || wr_addr == A_CFGC)) |=> rate_q == $past(wr_data[1:0]));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(outctl_q) && $stable(rate_q) && $stable(xchg_q) && $stable(four_q) && $stable(ps2_q)));

endmodule

// File: rtl/fdc_sel_decode.sv
// Drive select and motor decode.
// Two-drive mode: one select lane per drive, each gated by its own motor bit.
// Four-drive mode: the select pins carry the inverted drive number and the
// motor pins carry "selected motor on" and "any motor on", for an external
// 2-to-4 decoder. Outputs are active low. Also derives the drive 2/3 flag.
module fdc_sel_decode #(
    parameter int NDRV_DIRECT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             outctl,
    input  logic                   four_mode,
    input  logic                   xchg,
    output logic [NDRV_DIRECT-1:0] sel_n,
    output logic [NDRV_DIRECT-1:0] mot_n,
    output logic                   drv23
);
    localparam int DRV_W = $clog2(NDRV_DIRECT * 2);

    logic [DRV_W-1:0] drv_num;
    logic [3:0]       motors;
    logic             cur_motor;
    logic [NDRV_DIRECT-1:0] sel_dir_n;
    logic [NDRV_DIRECT-1:0] mot_dir_n;

    assign drv_num = outctl[DRV_W-1:0];
    assign motors  = outctl[7:4];

    // Motor bit belonging to the currently selected drive.
    always_comb cur_motor = motors[drv_num];

    genvar gi;
    generate
        for (gi = 0; gi < NDRV_DIRECT; gi++) begin : g_lane
            // Direct lane: select when addressed and its motor bit is set.
            always_comb begin
                sel_dir_n[gi] = !((drv_num == DRV_W'(gi)) && motors[gi]);
                mot_dir_n[gi] = !motors[gi];
            end
        end
    endgenerate

    // Choose direct or encoded pin meaning.
    always_comb begin
        if (four_mode) begin
            sel_n = ~drv_num;
            mot_n = {!(|motors), !cur_motor};
        end else begin
            sel_n = sel_dir_n;
            mot_n = mot_dir_n;
        end
    end

    // Drive 2/3 access flag, held off during logical exchange.
    always_comb drv23 = drv_num[DRV_W-1] && cur_motor && !xchg;

    assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !four_mode |-> $countones(~sel_n) <= 1);

    assert_no_d23_exchange_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xchg |-> !drv23);

    assert_d23_needs_motor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drv23 |-> (motors[3:2] != 2'b00));

endmodule

// File: rtl/fdc_rate_density.sv
// Rate and density outputs.
// Passes the current rate code to the pins and classifies it as high
// density (500 kbps, 1 Mbps) or low density (250, 300 kbps). The strap
// selects whether density is signalled high-true or low-true.
module fdc_rate_density
    import fdc_drive_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate,
    input  logic       dtype,
    output logic [1:0] rate_out,
    output logic       dens
);
    logic hi_dens;

    // Classify the rate code.
    always_comb begin
        case (rate)
            RATE_500K, RATE_1M: hi_dens = 1'b1;
            default:            hi_dens = 1'b0;
        endcase
    end

    // Drive the pins with strap-selected polarity.
    always_comb begin
        rate_out = rate;
        dens     = dtype ? hi_dens : !hi_dens;
    end

    assert_low_rate_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dtype && (rate_out == RATE_250K || rate_out == RATE_300K)) |-> !dens);

    assert_strap_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtype && (rate_out == RATE_500K || rate_out == RATE_1M)) |-> !dens);

endmodule

// File: rtl/fdc_drive_ctl.sv
// Top of the floppy drive control block.
// Ties the register file to the select decode and the rate/density logic,
// qualifies the DMA acknowledge by system mode, and gates step direction
// to seeks. Assumes all inputs are synchronous to clk.
module fdc_drive_ctl
    import fdc_drive_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              dtype_i,
    input  logic              dack_n_i,
    input  logic              seek_busy_i,
    input  logic              seek_in_i,
    output logic [1:0]        sel_n_o,
    output logic [1:0]        mot_n_o,
    output logic              drv23_o,
    output logic [1:0]        rate_o,
    output logic              dens_o,
    output logic              dack_n_o,
    output logic              dir_o
);
    logic [7:0] outctl;
    logic       xchg, four_mode, ps2_mode;
    logic [1:0] rate;

    fdc_ctl_regs #(.AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .outctl_q (outctl),
        .xchg_q   (xchg),
        .four_q   (four_mode),
        .ps2_q    (ps2_mode),
        .rate_q   (rate)
    );

    fdc_sel_decode #(.NDRV_DIRECT(2)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .outctl    (outctl),
        .four_mode (four_mode),
        .xchg      (xchg),
        .sel_n     (sel_n_o),
        .mot_n     (mot_n_o),
        .drv23     (drv23_o)
    );

    fdc_rate_density u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (rate),
        .dtype    (dtype_i),
        .rate_out (rate_o),
        .dens     (dens_o)
    );

    // Honour the acknowledge in PS/2 mode, or in AT mode when enabled.
    always_comb dack_n_o = dack_n_i | (!ps2_mode && !outctl[DMAEN_BIT]);

    // Step direction is only meaningful during a seek.
    always_comb dir_o = seek_busy_i && seek_in_i;

    assert_dack_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps2_mode && !outctl[DMAEN_BIT]) |-> dack_n_o);

    assert_dack_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ps2_mode |-> dack_n_o == dack_n_i);

    assert_dir_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !seek_busy_i |-> !dir_o);

endmodule

// File: tb/fdc_drive_ctl_test.sv
module fdc_drive_ctl_test;
    logic clk = 1'b0;
    logic rst_n;
    logic wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic dtype, dack_n, seek_busy, seek_in;
    logic [1:0] sel_n, mot_n, rate;
    logic drv23, dens, dack_g_n, dir;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_ctl;
    logic m_xchg, m_four, m_ps2;
    logic [1:0] m_rate;

    always #2.5 clk = ~clk;

    fdc_drive_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .dtype_i(dtype), .dack_n_i(dack_n),
        .seek_busy_i(seek_busy), .seek_in_i(seek_in), .sel_n_o(sel_n),
        .mot_n_o(mot_n), .drv23_o(drv23), .rate_o(rate), .dens_o(dens),
        .dack_n_o(dack_g_n), .dir_o(dir)
    );

    function automatic logic [1:0] exp_sel(logic [7:0] c, logic f);
        logic [1:0] r;
        if (f) return ~c[1:0];
        for (int i = 0; i < 2; i++) r[i] = !((c[1:0] == 2'(i)) && c[4+i]);
        return r;
    endfunction

    function automatic logic [1:0] exp_mot(logic [7:0] c, logic f);
        logic [3:0] m;
        m = c[7:4];
        if (f) return {!(|m), !m[c[1:0]]};
        return ~m[1:0];
    endfunction

    function automatic logic exp_d23(logic [7:0] c, logic x);
        logic [3:0] m;
        m = c[7:4];
        return c[1] && m[c[1:0]] && !x;
    endfunction

    function automatic logic exp_dens(logic [1:0] r, logic s);
        logic hi;
        hi = (r == 2'b00) || (r == 2'b11);
        return s ? hi : !hi;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // compare every output with the model; called at a negedge
    task automatic check_all();
        chk(m_four ? "R4 sel" : "R2 sel", 8'(sel_n), 8'(exp_sel(m_ctl, m_four)));
        chk(m_four ? "R4 mot" : "R3 mot", 8'(mot_n), 8'(exp_mot(m_ctl, m_four)));
        chk(m_xchg ? "R6 drv23" : "R5 drv23", 8'(drv23), 8'(exp_d23(m_ctl, m_xchg)));
        chk("R7 rate", 8'(rate), 8'(m_rate));
        chk(dtype ? "R8 dens" : "R9 dens", 8'(dens), 8'(exp_dens(m_rate, dtype)));
        chk(m_ps2 ? "R11 dack" : "R10 dack", 8'(dack_g_n),
            8'(dack_n | (!m_ps2 && !m_ctl[3])));
        chk("R12 dir", 8'(dir), 8'(seek_busy && seek_in));
    endtask

    task automatic model_write(logic [2:0] a, logic [7:0] d);
        case (a)
            3'd0: m_ctl = d;
            3'd1: m_xchg = d[3];
            3'd2, 3'd3: m_rate = d[1:0];
            3'd4: begin m_four = d[4]; m_ps2 = d[0]; end
            default: ;
        endcase
    endtask

    // one strobed write; R13: effect visible right after the capturing edge
    task automatic do_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check_all();
    endtask

    initial begin
        #100us;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'h00;
        dtype = 1'b1; dack_n = 1'b0; seek_busy = 1'b0; seek_in = 1'b1;
        m_ctl = 8'h00; m_xchg = 1'b0; m_four = 1'b0; m_ps2 = 1'b0; m_rate = 2'b10;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sel", 8'(sel_n), 8'h3);
        chk("R1 mot", 8'(mot_n), 8'h3);
        chk("R1 rate", 8'(rate), 8'h2);
        chk("R1 drv23", 8'(drv23), 8'h0);
        chk("R1 dack", 8'(dack_g_n), 8'h1);
        chk("R1 dens", 8'(dens), 8'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R2/R3: drive 1 with its motor, then drive 0 without its motor
        do_write(3'd0, 8'h21);
        do_write(3'd0, 8'h20);
        // R10: DMA enable bit in AT mode
        do_write(3'd0, 8'h18);
        // R5: drive 2 accessed, R6: exchange suppresses
        do_write(3'd0, 8'h42);
        do_write(3'd1, 8'h08);
        do_write(3'd4, 8'h10);
        do_write(3'd1, 8'h00);
        do_write(3'd0, 8'h83);
        // R11: PS/2 mode ignores bit 3
        do_write(3'd4, 8'h01);
        do_write(3'd0, 8'h00);
        // R7: ordering between the two rate registers
        do_write(3'd3, 8'hFF);
        do_write(3'd2, 8'h01);
        do_write(3'd2, 8'h00);
        do_write(3'd3, 8'hFE);
        dtype = 1'b0;
        @(negedge clk); check_all();
        // R13: no strobe and unused addresses change nothing
        @(negedge clk);
        wr_addr = 3'd0; wr_data = 8'hFF; wr_en = 1'b0;
        @(negedge clk); check_all();
        do_write(3'd5, 8'hFF);
        do_write(3'd7, 8'h13);
        // R12: seek gating
        seek_busy = 1'b1; seek_in = 1'b1; @(negedge clk); check_all();
        seek_in = 1'b0; @(negedge clk); check_all();

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            dtype = 1'($urandom);
            dack_n = 1'($urandom);
            seek_busy = 1'($urandom);
            seek_in = 1'($urandom);
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk);
                wr_en = 1'b0; wr_addr = a; wr_data = d;
                @(negedge clk);
                check_all();
            end else begin
                do_write(a, d);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule